// File: doc/BRIEF.md
# Masked GPIO Port Register File

This block holds the software-visible state of a bank of 32-bit general purpose I/O ports: a direction word, an output word and a mask word per port. A processor reaches that state through a simple synchronous register bus. Besides plain whole-word writes, it can set, clear or invert chosen output bits in a single write, so no read-modify-write sequence is needed. It can also address one pin on its own through a per-pin alias register.

A masked view lets software read and write only a chosen subset of a port's pins. In the mask word a 0 bit means the pin takes part and a 1 bit means it is left out. Every read returns the pin level, which is the driven output value for output pins and the sampled input bus for input pins. Pad synchronisers, pin multiplexing and interrupt logic sit outside this block. The bus is a plain register interface with no handshake: every write completes in the cycle it is presented, and every read returns its data one cycle later.

Top module: `gpiom_top`

## Requirements
- R1: After reset every direction bit is 0 (input), every output bit is 0 and every mask bit is 0.
- R2: Writing region DIR loads the port's direction word. Bit value 1 makes the pin an output, and pin_oe mirrors the direction word. Reading DIR returns it.
- R3: A write to region SET sets to 1 each output bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to region CLR forces to 0 each output bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A write to region TGL inverts each output bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: A write to region BIT with pin field n sets output bit n to bus_wdata[0]. A read of region BIT returns that pin's level in bit 0, with bits 31:1 at 0.
- R7: A read of region PIN returns the level of all 32 pins. For each pin the level is the output bit when its direction is 1 and pin_in when its direction is 0. A write to PIN loads the whole output word.
- R8: Writing region MASK loads the mask word, and reading it returns the mask word.
- R9: A write to region MPIN changes only the output bits whose mask bit is 0. Output bits whose mask bit is 1 keep their value.
- R10: A read of region MPIN returns the pin levels with every pin whose mask bit is 1 forced to 0.
- R11: Reads of regions SET, CLR and TGL return the port's current output word.
- R12: The address is {region[2:0], port, pin[4:0]}, with region codes BIT=0, DIR=1, PIN=2, SET=3, CLR=4, TGL=5, MASK=6, MPIN=7. A write reaches only the addressed port, and the pin field is used only by region BIT.
- R13: bus_rdata is registered. It shows the data for the address presented at the previous clock edge, taken from the state before any write made at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Register address {region, port, pin} |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| pin_in | input | 64 | Sampled pin inputs, port p in bits [32p+31:32p] |
| pin_out | output | 64 | Output data word per port |
| pin_oe | output | 64 | Output enable per pin (the direction word) |

## Verification
The hardest state to reach from the ports is the one where direction, mask and output words all hold mixed patterns on the same port while pin_in differs from the output word. Only in that state do masked reads and writes, and alias reads, separate the correct level source from a wrong one. The stimulus gets there in two ways. Directed writes first build such patterns on both ports. A long random sequence then mixes every region with new random pin_in values on each operation, and some random writes land in the same cycle as a read of the same register, which exercises the pre-write read timing.

// File: rtl/gpiom_pkg.sv
package gpiom_pkg;

  typedef enum logic [2:0] {
    RG_BIT  = 3'd0,
    RG_DIR  = 3'd1,
    RG_PIN  = 3'd2,
    RG_SET  = 3'd3,
    RG_CLR  = 3'd4,
    RG_TGL  = 3'd5,
    RG_MASK = 3'd6,
    RG_MPIN = 3'd7
  } gpiom_region_e;

  typedef struct packed {
    logic dir;
    logic pin;
    logic set;
    logic clr;
    logic tgl;
    logic mask;
    logic mpin;
    logic bitw;
  } gpiom_wsel_t;

endpackage

// File: rtl/gpiom_decode.sv
module gpiom_decode
  import gpiom_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int PORT_W = 1,
  parameter int PIN_W  = 5,
  localparam int ADDR_W = 3 + PORT_W + PIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output gpiom_region_e     region,
  output logic [PORT_W-1:0] port_idx,
  output logic [PIN_W-1:0]  pin_idx,
  output logic [NPORTS-1:0] port_hit,
  output gpiom_wsel_t       wsel
);

  assign region   = gpiom_region_e'(addr[ADDR_W-1 -: 3]);
  assign port_idx = addr[PIN_W +: PORT_W];
  assign pin_idx  = addr[PIN_W-1:0];

  for (genvar p = 0; p < NPORTS; p++) begin : g_hit
    assign port_hit[p] = we && (port_idx == PORT_W'(p));
  end

  always_comb begin
    wsel      = '0;
    wsel.bitw = we && (region == RG_BIT);
    wsel.dir  = we && (region == RG_DIR);
    wsel.pin  = we && (region == RG_PIN);
    wsel.set  = we && (region == RG_SET);
    wsel.clr  = we && (region == RG_CLR);
    wsel.tgl  = we && (region == RG_TGL);
    wsel.mask = we && (region == RG_MASK);
    wsel.mpin = we && (region == RG_MPIN);
  end

  // R12: a write reaches at most one port
  p_hit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_hit));

endmodule

// File: rtl/gpiom_port.sv
module gpiom_port
  import gpiom_pkg::*;
#(
  parameter int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  gpiom_wsel_t   sel,
  input  logic [IW-1:0] bit_idx,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  out_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  mask_q,
  output logic [W-1:0]  level
);

  logic [W-1:0] out_nxt;
  logic         past_ok;

  always_comb begin
    out_nxt = out_q;
    if (sel.pin)  out_nxt = wdata;
    if (sel.set)  out_nxt = out_nxt | wdata;
    if (sel.clr)  out_nxt = out_nxt & ~wdata;
    if (sel.tgl)  out_nxt = out_nxt ^ wdata;
    if (sel.mpin) out_nxt = (out_q & mask_q) | (wdata & ~mask_q);
    if (sel.bitw) out_nxt[bit_idx] = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      mask_q  <= '0;
      past_ok <= 1'b0;
    end else begin
      out_q   <= out_nxt;
      past_ok <= 1'b1;
      if (sel.dir)  dir_q  <= wdata;
      if (sel.mask) mask_q <= wdata;
    end
  end

  assign level = (dir_q & out_q) | (~dir_q & pin_in);

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(sel.set) |-> (out_q == ($past(out_q) | $past(wdata))));

  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(sel.clr) |-> (out_q == ($past(out_q) & ~$past(wdata))));

  p_tgl_r5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(sel.tgl) |-> (out_q == ($past(out_q) ^ $past(wdata))));

  p_bit_r6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(sel.bitw) |-> (out_q[$past(bit_idx)] == $past(wdata[0])));

  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(sel.mask) |-> (mask_q == $past(wdata)));

  p_mpin_r9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(sel.mpin) |-> ((out_q & $past(mask_q)) == ($past(out_q) & $past(mask_q))));

  p_dirhold_r2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !$past(sel.dir) |-> $stable(dir_q));

endmodule

// File: rtl/gpiom_rdmux.sv
module gpiom_rdmux
  import gpiom_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int W      = 32,
  parameter int PORT_W = 1,
  localparam int IW = $clog2(W)
) (
  input  gpiom_region_e       region,
  input  logic [PORT_W-1:0]   port_idx,
  input  logic [IW-1:0]       pin_idx,
  input  logic [NPORTS*W-1:0] levels,
  input  logic [NPORTS*W-1:0] outs,
  input  logic [NPORTS*W-1:0] dirs,
  input  logic [NPORTS*W-1:0] masks,
  output logic [W-1:0]        rdata
);

  logic [W-1:0] lvl, outw, dirw, mskw;

  always_comb begin
    lvl  = '0;
    outw = '0;
    dirw = '0;
    mskw = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (port_idx == PORT_W'(p)) begin
        lvl  = levels[p*W +: W];
        outw = outs[p*W +: W];
        dirw = dirs[p*W +: W];
        mskw = masks[p*W +: W];
      end
    end
    unique case (region)
      RG_BIT:  rdata = {{(W-1){1'b0}}, lvl[pin_idx]};
      RG_DIR:  rdata = dirw;
      RG_PIN:  rdata = lvl;
      RG_SET,
      RG_CLR,
      RG_TGL:  rdata = outw;
      RG_MASK: rdata = mskw;
      RG_MPIN: rdata = lvl & ~mskw;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpiom_top.sv
module gpiom_top
  import gpiom_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int W      = 32,
  localparam int PIN_W  = $clog2(W),
  localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int ADDR_W = 3 + PORT_W + PIN_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [W-1:0]        bus_wdata,
  output logic [W-1:0]        bus_rdata,
  input  logic [NPORTS*W-1:0] pin_in,
  output logic [NPORTS*W-1:0] pin_out,
  output logic [NPORTS*W-1:0] pin_oe
);

  gpiom_region_e       region;
  logic [PORT_W-1:0]   port_idx;
  logic [PIN_W-1:0]    pin_idx;
  logic [NPORTS-1:0]   port_hit;
  gpiom_wsel_t         wsel;
  logic [NPORTS*W-1:0] levels, masks;
  logic [W-1:0]        rd_nxt;

  gpiom_decode #(.NPORTS(NPORTS), .PORT_W(PORT_W), .PIN_W(PIN_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
    .region(region), .port_idx(port_idx), .pin_idx(pin_idx),
    .port_hit(port_hit), .wsel(wsel)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    gpiom_wsel_t sel_p;
    assign sel_p = port_hit[p] ? wsel : '0;
    gpiom_port #(.W(W)) u_port (
      .clk(clk), .rst_n(rst_n), .sel(sel_p), .bit_idx(pin_idx),
      .wdata(bus_wdata), .pin_in(pin_in[p*W +: W]),
      .out_q(pin_out[p*W +: W]), .dir_q(pin_oe[p*W +: W]),
      .mask_q(masks[p*W +: W]), .level(levels[p*W +: W])
    );
  end

  gpiom_rdmux #(.NPORTS(NPORTS), .W(W), .PORT_W(PORT_W)) u_rd (
    .region(region), .port_idx(port_idx), .pin_idx(pin_idx),
    .levels(levels), .outs(pin_out), .dirs(pin_oe), .masks(masks),
    .rdata(rd_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_nxt;
  end

  // R1: state held at zero while in reset
  p_rst_r1: assert property (@(posedge clk) !rst_n |-> (pin_out == '0 && pin_oe == '0));

endmodule

// File: tb/gpiom_top_tb_top.sv
module gpiom_top_tb_top;
  localparam int NP = 2;
  localparam int W  = 32;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [NP*W-1:0] pin_in = '0, pin_out, pin_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [W-1:0] m_out [NP];
  logic [W-1:0] m_dir [NP];
  logic [W-1:0] m_msk [NP];

  always #2 clk = ~clk;

  gpiom_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(int rg, int p, int b);
    return {3'(rg), 1'(p), 5'(b)};
  endfunction

  function automatic logic [W-1:0] lvl(int p);
    return (m_dir[p] & m_out[p]) | (~m_dir[p] & pin_in[p*W +: W]);
  endfunction

  function automatic logic [W-1:0] model_rd(int rg, int p, int b);
    logic [W-1:0] l = lvl(p);
    case (rg)
      0: return {31'b0, l[b]};
      1: return m_dir[p];
      2: return l;
      3, 4, 5: return m_out[p];
      6: return m_msk[p];
      default: return l & ~m_msk[p];
    endcase
  endfunction

  function automatic string rtag(int rg);
    case (rg)
      0: return "R6"; 1: return "R2"; 2: return "R7"; 6: return "R8";
      7: return "R10"; default: return "R11";
    endcase
  endfunction

  function automatic string wtag(int rg);
    case (rg)
      0: return "R6"; 1: return "R2"; 2: return "R7"; 3: return "R3";
      4: return "R4"; 5: return "R5"; 6: return "R8"; default: return "R9";
    endcase
  endfunction

  // one bus cycle; read data is compared one cycle later against pre-write state (R13)
  task automatic do_op(int rg, int p, int b, bit we, logic [W-1:0] d, logic [NP*W-1:0] pins);
    logic [W-1:0] exp_rd;
    @(negedge clk);
    pin_in    = pins;
    bus_addr  = mk_addr(rg, p, b);
    bus_we    = we;
    bus_wdata = d;
    exp_rd = model_rd(rg, p, b);
    if (we) begin
      case (rg)
        0: m_out[p][b] = d[0];
        1: m_dir[p] = d;
        2: m_out[p] = d;
        3: m_out[p] = m_out[p] | d;
        4: m_out[p] = m_out[p] & ~d;
        5: m_out[p] = m_out[p] ^ d;
        6: m_msk[p] = d;
        default: m_out[p] = (m_out[p] & m_msk[p]) | (d & ~m_msk[p]);
      endcase
    end
    @(negedge clk);
    bus_we = 1'b0;
    check({rtag(rg), " R13 read"}, 64'(bus_rdata), 64'(exp_rd));
    check({wtag(rg), " R12 pin_out"}, pin_out, {m_out[1], m_out[0]});
    check({wtag(rg), " R2 pin_oe"}, pin_oe, {m_dir[1], m_dir[0]});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5EED_1234;
    void'($urandom(seed));
    for (int p = 0; p < NP; p++) begin
      m_out[p] = '0; m_dir[p] = '0; m_msk[p] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_out", pin_out, '0);
    check("R1 pin_oe", pin_oe, '0);
    do_op(6, 0, 0, 0, '0, pin_in);
    do_op(6, 1, 0, 0, '0, pin_in);

    // R2 direction, R3/R4/R5 bit operations, R11 readback
    do_op(1, 0, 0, 1, 32'h0000_FFFF, 64'hA5A5_5A5A_C3C3_3C3C);
    do_op(1, 0, 0, 0, '0, pin_in);
    do_op(3, 0, 0, 1, 32'hF0F0_00FF, pin_in);
    do_op(4, 0, 0, 1, 32'h0000_000F, pin_in);
    do_op(5, 0, 0, 1, 32'hFFFF_0000, pin_in);
    do_op(4, 0, 0, 0, '0, pin_in);
    do_op(5, 1, 0, 0, '0, pin_in);
    check("R12 port1 untouched", 64'(pin_out[63:32]), 64'h0);

    // R6 alias on highest pin of last port, input and output reads
    do_op(0, 1, 31, 1, 32'h0000_0001, pin_in);
    do_op(0, 1, 31, 0, '0, 64'h0000_0000_FFFF_FFFF);
    do_op(1, 1, 0, 1, 32'h8000_0000, pin_in);
    do_op(0, 1, 31, 0, '0, pin_in);
    do_op(0, 1, 30, 1, 32'hFFFF_FFFE, pin_in);
    do_op(0, 0, 20, 0, '0, 64'h0000_0000_0010_0000);

    // R7 pin read, R8 mask, R9/R10 masked view
    do_op(2, 0, 0, 0, '0, 64'h1234_5678_9ABC_DEF0);
    do_op(6, 0, 0, 1, 32'hFF00_FF00, pin_in);
    do_op(6, 0, 0, 0, '0, pin_in);
    do_op(7, 0, 0, 1, 32'hAAAA_AAAA, pin_in);
    do_op(7, 0, 0, 0, '0, pin_in);
    do_op(2, 1, 0, 1, 32'h0F0F_0F0F, pin_in);

    // R13 write and read of same register in one cycle
    do_op(3, 0, 0, 1, 32'h0101_0101, pin_in);

    for (int i = 0; i < 600; i++) begin
      int rg = $urandom_range(0, 7);
      int p  = $urandom_range(0, NP - 1);
      int b  = $urandom_range(0, 31);
      bit we = 1'($urandom_range(0, 1));
      logic [W-1:0] d = $urandom;
      logic [NP*W-1:0] pins = {$urandom, $urandom};
      do_op(rg, p, (rg == 0) ? b : $urandom_range(0, 31), we, d, pins);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule